// File: doc/BRIEF.md
# Burst-holding bus arbiter for eight DMA channels

This block sits between eight DMA channels and one shared memory bus. A channel raises its request bit when it has a burst ready. The arbiter picks one requester, grants it the bus, and keeps that grant until the channel pulses burst-done. The bus is never taken away in the middle of a burst. Requests are latched into a decision only while no grant is active.

A 32-bit global control word selects the behaviour. Bit 0 is a global enable; while it is clear, no new grant is issued. Bit 31 selects the selection policy. When it is 0, the lowest-numbered requester wins. When it is 1, the policy is round robin: the search starts at the channel after the last one granted and wraps from 7 to 0. The policy bit is read only when a decision is taken, so a switch between policies never disturbs a burst that is already running.

Grants are registered. A request seen in an idle cycle produces a grant in the next cycle. After burst-done the grant drops in the next cycle, which leaves exactly one idle cycle before the following grant.

Top module: `dma_bus_arbiter`

## Requirements
- R1: With control bit 31 = 0 and control bit 0 = 1, a decision taken in an idle cycle grants the lowest-numbered channel whose request bit is set. The grant is visible in the next cycle.
- R2: `grant_o` is one-hot or all zero. `grant_valid_o` is 1 exactly when a grant is held. `grant_idx_o` equals the index of the granted bit, and it is 0 when no grant is held.
- R3: While a grant is held and `burst_done_i` is low, `grant_o` stays unchanged whatever the request bits do.
- R4: While control bit 0 is clear, no new grant is issued. A burst already granted continues until its burst-done.
- R5: With control bit 31 = 1, a decision grants the first requesting channel found when searching upward from the channel after the last one granted. The search wraps from 7 to 0.
- R6: When `burst_done_i` is high in a cycle where a grant is held, `grant_o` is all zero in the next cycle. A new grant can appear at the earliest one cycle after that.
- R7: Control bit 31 is sampled only in the cycle of a decision. Changing it during a held burst leaves that grant unchanged. The next decision uses the new value.
- R8: Reset (`rst_ni` low) clears all grants. It sets the round-robin history so that the first round-robin search starts at channel 0.
- R9: `burst_done_i` asserted while no grant is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gctl_i | input | 32 | Global control word: bit 0 enable, bit 31 policy (0 fixed, 1 round robin) |
| req_i | input | 8 | Per-channel burst request |
| burst_done_i | input | 1 | Pulse from the granted channel marking its last beat |
| grant_o | output | 8 | One-hot bus grant |
| grant_valid_o | output | 1 | A grant is held |
| grant_idx_o | output | 3 | Index of the granted channel |

## Verification
Every result is due one clock after the cycle whose inputs cause it:
- A decision in an idle cycle shows up as a grant one cycle later.
- A burst-done drops the grant one cycle later, so the next grant comes two cycles after the burst-done at the earliest.
- Hold, enable gating and policy changes are judged on the cycle that follows the stimulus.

The bench drives inputs on the falling edge and advances its reference model with those inputs. It compares all three outputs with the model at the next falling edge, half a period after the register update.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned GCTL_W  = 32;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned POL_BIT = 31;

  typedef enum logic {
    POL_FIXED = 1'b0,
    POL_RR    = 1'b1
  } arb_pol_e;
endpackage

// File: rtl/fixed_prio_pick.sv
module fixed_prio_pick #(
  parameter int unsigned N_CH = 8,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0]  req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (valid_o) begin
      a_r1_pick_is_req: assert (req_i[idx_o]);
    end
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N_CH = 8,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0]  req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0]  start;
  logic [2*N_CH-1:0] dbl;
  logic [N_CH-1:0]   rot;
  logic [IDX_W-1:0]  off;
  logic [IDX_W:0]    sum;

  assign start = (32'(last_i) == N_CH - 1) ? '0 : last_i + 1'b1;
  assign dbl   = {req_i, req_i} >> start;
  assign rot   = dbl[N_CH-1:0];

  fixed_prio_pick #(.N_CH(N_CH)) u_rot_pick (
    .req_i   (rot),
    .valid_o (valid_o),
    .idx_o   (off)
  );

  // offset back into channel space, modulo N_CH
  assign sum   = {1'b0, off} + {1'b0, start};
  assign idx_o = (32'(sum) >= N_CH) ? IDX_W'(32'(sum) - N_CH) : sum[IDX_W-1:0];

  always_comb begin
    if (valid_o) begin
      a_r5_rr_pick_is_req: assert (req_i[idx_o]);
    end
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GCTL_W-1:0] gctl_i,
  input  logic [N_CH-1:0]   req_i,
  input  logic              burst_done_i,
  output logic [N_CH-1:0]   grant_o,
  output logic              grant_valid_o,
  output logic [IDX_W-1:0]  grant_idx_o
);
  logic             busy_q;
  logic [N_CH-1:0]  grant_q;
  logic [IDX_W-1:0] idx_q, last_q;

  logic             fx_v, rr_v, pick_v, en;
  logic [IDX_W-1:0] fx_idx, rr_idx, pick_idx;
  arb_pol_e         pol;

  assign en  = gctl_i[EN_BIT];
  assign pol = arb_pol_e'(gctl_i[POL_BIT]);

  fixed_prio_pick #(.N_CH(N_CH)) u_fixed (
    .req_i   (req_i),
    .valid_o (fx_v),
    .idx_o   (fx_idx)
  );

  rr_pick #(.N_CH(N_CH)) u_rr (
    .req_i   (req_i),
    .last_i  (last_q),
    .valid_o (rr_v),
    .idx_o   (rr_idx)
  );

  always_comb begin
    if (pol == POL_RR) begin
      pick_v   = rr_v;
      pick_idx = rr_idx;
    end else begin
      pick_v   = fx_v;
      pick_idx = fx_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
      idx_q   <= '0;
      last_q  <= IDX_W'(N_CH - 1);
    end else if (busy_q) begin
      if (burst_done_i) begin
        busy_q  <= 1'b0;
        grant_q <= '0;
        idx_q   <= '0;
      end
    end else if (en && pick_v) begin
      busy_q  <= 1'b1;
      grant_q <= {{(N_CH-1){1'b0}}, 1'b1} << pick_idx;
      idx_q   <= pick_idx;
      last_q  <= pick_idx;
    end
  end

  assign grant_o       = grant_q;
  assign grant_valid_o = busy_q;
  assign grant_idx_o   = idx_q;

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && !burst_done_i |=> grant_valid_o && $stable(grant_o));

  a_r4_no_grant_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o && !gctl_i[EN_BIT] |=> !grant_valid_o);

  a_r6_gap_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && burst_done_i |=> grant_o == '0);

  a_r1_fixed_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o && gctl_i[EN_BIT] && !gctl_i[POL_BIT] && (req_i != '0)
    |=> ((($past(req_i) & grant_o) != '0) && (($past(req_i) & (grant_o - 1'b1)) == '0)));

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o && burst_done_i && (!gctl_i[EN_BIT] || req_i == '0) |=> !grant_valid_o);
endmodule

// File: tb/dma_bus_arbiter_test.sv
`timescale 1ns/1ps
module dma_bus_arbiter_test;
  localparam int N = 8;
  localparam logic [31:0] EN = 32'h0000_0001;
  localparam logic [31:0] RR = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] gctl = '0;
  logic [7:0]  req = '0;
  logic        done = 1'b0;
  logic [7:0]  grant;
  logic        gv;
  logic [2:0]  gidx;

  int checks = 0;
  int fails  = 0;

  bit       m_busy = 1'b0;
  bit [2:0] m_idx  = '0;
  bit [2:0] m_last = 3'd7;
  string    m_tag  = "R8";

  always #4 clk = ~clk;

  dma_bus_arbiter uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .gctl_i        (gctl),
    .req_i         (req),
    .burst_done_i  (done),
    .grant_o       (grant),
    .grant_valid_o (gv),
    .grant_idx_o   (gidx)
  );

  function automatic int pick_low(input logic [7:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic int pick_next(input logic [7:0] r, input int last);
    for (int k = 1; k <= N; k++) begin
      int c = (last + k) % N;
      if (r[c]) return c;
    end
    return -1;
  endfunction

  task automatic check_out(input string tag);
    logic [7:0] eg;
    eg = m_busy ? (8'd1 << m_idx) : 8'd0;
    checks++;
    if (grant !== eg || gv !== m_busy || gidx !== m_idx) begin
      fails++;
      $display("FAIL %s: grant=%h valid=%b idx=%0d expected grant=%h valid=%b idx=%0d",
               tag, grant, gv, gidx, eg, m_busy, m_idx);
    end
    checks++;
    if ($countones(grant) > 1 || gv !== (grant != 0)) begin
      fails++;
      $display("FAIL R2: grant=%h valid=%b expected one-hot matching valid", grant, gv);
    end
  endtask

  task automatic tick(input logic [7:0] r, input logic d, input logic [31:0] g, input string tag);
    string auto_tag;
    @(negedge clk);
    check_out(m_tag);
    req = r; done = d; gctl = g;
    if (m_busy) begin
      if (d) begin
        m_busy = 1'b0; m_idx = '0; auto_tag = "R6";
      end else auto_tag = "R3";
    end else begin
      auto_tag = d ? "R9" : "R4";
      if (g[0] && r != 0) begin
        int p;
        p = g[31] ? pick_next(r, int'(m_last)) : pick_low(r);
        m_busy = 1'b1; m_idx = p[2:0]; m_last = p[2:0];
        auto_tag = g[31] ? "R5" : "R1";
      end
    end
    m_tag = (tag != "") ? tag : auto_tag;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R8: outputs idle in reset
    @(negedge clk); check_out("R8");
    @(negedge clk); check_out("R8");
    rst_ni = 1'b1;

    // R8: first round-robin search begins at channel 0
    tick(8'hff, 0, EN | RR, "R8");
    tick(8'hfe, 0, EN | RR, "R3");
    tick(8'h00, 0, EN | RR, "R3");
    tick(8'h00, 1, EN | RR, "R6");
    tick(8'hff, 0, EN | RR, "R5");     // -> channel 1 after gap
    tick(8'h00, 1, EN | RR, "R6");
    // R5 wrap: grant 7 then search wraps to 0
    tick(8'h80, 0, EN | RR, "R5");
    tick(8'h00, 1, EN | RR, "R6");
    tick(8'hff, 0, EN | RR, "R5");
    tick(8'h00, 1, EN, "R6");
    // R1 fixed priority
    tick(8'hff, 0, EN, "R1");
    tick(8'h00, 1, EN, "R6");
    tick(8'h0c, 0, EN, "R1");
    // R7: policy flip during burst has no effect on it
    tick(8'hff, 0, EN | RR, "R7");
    tick(8'h01, 0, EN | RR, "R7");
    tick(8'h00, 1, EN | RR, "R6");
    tick(8'hff, 0, EN | RR, "R7");     // rr after 2 -> 3
    tick(8'h00, 1, 32'h0, "R6");
    // R4: disabled, no grant; disabling during burst keeps it
    tick(8'hff, 0, 32'h0, "R4");
    tick(8'hff, 0, 32'h0, "R4");
    tick(8'h20, 0, EN, "R4");
    tick(8'hff, 0, 32'h0, "R4");
    tick(8'hff, 0, 32'h0, "R4");
    tick(8'h00, 1, 32'h0, "R6");
    // R9: done with no grant ignored
    tick(8'h00, 1, EN, "R9");
    tick(8'h00, 1, 32'h0, "R9");
    tick(8'h10, 1, EN, "R9");
    tick(8'h00, 0, EN, "R9");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] g;
      g = gctl;
      if (($urandom() % 8) == 0) g[31] = ~g[31];
      g[0] = (($urandom() % 10) != 0);
      tick(8'($urandom()), (($urandom() % 4) == 0), g, "");
    end
    @(negedge clk); check_out(m_tag);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule